// File: doc/BRIEF.md
# Flow-Through Burst SRAM Core

This block is a single-port synchronous SRAM with two byte lanes and a built-in four-beat burst address sequencer. A burst-start strobe registers a full word address. After that, an advance strobe steps the two low address bits through one of two fixed orders. The interleaved order XORs the start bits with the beat number. The linear order adds the beat number to the start bits, modulo four. The upper address bits do not change during a burst, so a burst always stays inside its aligned group of four words.

Every cycle is an access to the current burst address. Writes are qualified by a global write enable, a byte-write enable and one write strobe per lane. Reads are flow-through: array data for the current address reaches the output in the same cycle, with no output register. The output is driven only during a read with output enable asserted. A sleep input overrides everything: no access takes effect, the output is not driven, and the sequencer holds. The interface has no stream. Every pin is a plain level or strobe, sampled on the rising clock edge, so no back-pressure exists.

Top module: `fsram_burst_core`

## Requirements
- R1: After reset, the current address is 0, so an access made before any burst start goes to word 0.
- R2: With `gwe_n` low (and `sleep` low), both lanes are written from `wdata`, whatever `bwe_n` and `lane_we_n` are.
- R3: With `gwe_n` high and `bwe_n` low, lane i (bits 8i+7:8i) is written exactly when `lane_we_n[i]` is low.
- R4: With `gwe_n` high and either `bwe_n` high or both `lane_we_n` bits high, the cycle is a read and no lane is written.
- R5: With `order_sel` = 1 at burst start, beat k (k = 0..3) has low address bits equal to start XOR k.
- R6: With `order_sel` = 0 at burst start, beat k has low address bits equal to (start + k) mod 4.
- R7: An advance after the fourth beat returns to beat 0, and the upper address bits stay at their loaded value for the whole burst.
- R8: `burst_start` reloads the full address and restarts at beat 0. It takes priority over a simultaneous `burst_adv`.
- R9: Read data for the current address appears on `q` in the same cycle, without an extra register stage.
- R10: `q_drv` is 1 only during a read with `oe_n` low. It is 0 during any write cycle and whenever `oe_n` is high, and `q` is zero whenever `q_drv` is 0.
- R11: While `sleep` is high, no lane is written, `q_drv` is 0, and burst start and advance strobes are ignored.
- R12: The burst order is captured at burst start. Changing `order_sel` in the middle of a burst has no effect until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the sequencer |
| burst_start | input | 1 | Load `addr` and restart the burst at beat 0 |
| burst_adv | input | 1 | Step to the next beat of the burst |
| addr | input | ADDR_W | Word address captured on burst start |
| order_sel | input | 1 | Burst order captured on start: 1 interleaved, 0 linear |
| gwe_n | input | 1 | Global write enable, active low, writes all lanes |
| bwe_n | input | 1 | Byte-write enable, active low |
| lane_we_n | input | LANES | Per-lane write strobes, active low |
| oe_n | input | 1 | Output enable, active low |
| sleep | input | 1 | Power-down; blocks all accesses and output drive (tie low if unused) |
| wdata | input | LANES*LANE_W | Write data for the current address |
| q | output | LANES*LANE_W | Flow-through read data, zero when not driven |
| q_drv | output | 1 | High when `q` is actively driven |

## Verification
The decode of the write controls and the output-drive decision are combinational, so `q_drv` is checked in the same cycle that the controls are applied. A write becomes visible on `q` from the cycle after its clock edge. Each burst start or advance takes effect on the following rising edge, and the flow-through data for the new beat is due one cycle after the strobe. The bench therefore changes inputs just after a falling edge. It samples one nanosecond later, before the next rising edge, so that every expected value is read in the cycle to which the counted register stages assign it.

// File: rtl/fsram_pkg.sv
package fsram_pkg;

  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } burst_ord_e;

  localparam int BEAT_W = 2;

  function automatic logic [BEAT_W-1:0] beat_low(
    input burst_ord_e           ord,
    input logic [BEAT_W-1:0]    start,
    input logic [BEAT_W-1:0]    beat
  );
    logic [BEAT_W-1:0] r;
    if (ord == ORD_XOR) r = start ^ beat;
    else                r = start + beat;
    return r;
  endfunction

endpackage

// File: rtl/fsram_burst_seq.sv
module fsram_burst_seq
  import fsram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              ord_in,
  output logic [ADDR_W-1:0] cur_addr
);

  localparam int UP_W = ADDR_W - BEAT_W;

  logic [UP_W-1:0]   upper_q;
  logic [BEAT_W-1:0] start_q;
  logic [BEAT_W-1:0] beat_q;
  burst_ord_e        ord_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upper_q <= '0;
      start_q <= '0;
      beat_q  <= '0;
      ord_q   <= ORD_LINEAR;
    end else if (!sleep) begin
      if (load) begin
        upper_q <= addr_in[ADDR_W-1:BEAT_W];
        start_q <= addr_in[BEAT_W-1:0];
        beat_q  <= '0;
        ord_q   <= burst_ord_e'(ord_in);
      end else if (step) begin
        beat_q  <= beat_q + 2'd1;
      end
    end
  end

  assign cur_addr = {upper_q, beat_low(ord_q, start_q, beat_q)};

  // R8
  restart_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !sleep) |=> (cur_addr == $past(addr_in)));

  // R7
  upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(cur_addr[ADDR_W-1:BEAT_W]));

  // R7
  beat_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !sleep && beat_q == 2'd3) |=> (beat_q == 2'd0));

  // R11
  sleep_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> $stable(cur_addr));

endmodule

// File: rtl/fsram_we_dec.sv
module fsram_we_dec #(
  parameter int LANES = 2
) (
  input  logic             sleep,
  input  logic             gwe_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] lane_we_n,
  output logic [LANES-1:0] lane_we
);

  always_comb begin
    if (sleep)       lane_we = '0;
    else if (!gwe_n) lane_we = '1;
    else if (!bwe_n) lane_we = ~lane_we_n;
    else             lane_we = '0;
  end

endmodule

// File: rtl/fsram_lane_array.sv
module fsram_lane_array #(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANE_W-1:0] wdata,
  output logic [LANE_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];

endmodule

// File: rtl/fsram_burst_core.sv
module fsram_burst_core
  import fsram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 8,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    burst_start,
  input  logic                    burst_adv,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    order_sel,
  input  logic                    gwe_n,
  input  logic                    bwe_n,
  input  logic [LANES-1:0]        lane_we_n,
  input  logic                    oe_n,
  input  logic                    sleep,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] q,
  output logic                    q_drv
);

  localparam int DATA_W = LANES * LANE_W;

  logic [ADDR_W-1:0] cur_addr;
  logic [LANES-1:0]  lane_we;
  logic [DATA_W-1:0] rd_word;

  fsram_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .sleep    (sleep),
    .load     (burst_start),
    .step     (burst_adv),
    .addr_in  (addr),
    .ord_in   (order_sel),
    .cur_addr (cur_addr)
  );

  fsram_we_dec #(.LANES(LANES)) u_dec (
    .sleep     (sleep),
    .gwe_n     (gwe_n),
    .bwe_n     (bwe_n),
    .lane_we_n (lane_we_n),
    .lane_we   (lane_we)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    fsram_lane_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_arr (
      .clk   (clk),
      .we    (lane_we[l]),
      .addr  (cur_addr),
      .wdata (wdata[l*LANE_W +: LANE_W]),
      .rdata (rd_word[l*LANE_W +: LANE_W])
    );
  end

  assign q_drv = !sleep && !oe_n && (lane_we == '0);
  assign q     = q_drv ? rd_word : '0;

  // R2
  gwe_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !gwe_n) |-> (&lane_we));

  // R3
  lane_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && gwe_n && !bwe_n) |-> (lane_we == ~lane_we_n));

  // R4
  read_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gwe_n && (bwe_n || (&lane_we_n))) |-> (lane_we == '0));

  // R10
  no_drive_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|lane_we) |-> !q_drv);

  // R11
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> (!q_drv && lane_we == '0));

endmodule

// File: tb/sim_fsram_burst_core.sv
`timescale 1ns/1ps
module sim_fsram_burst_core;

  localparam int AW = 6;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          burst_start, burst_adv, order_sel;
  logic [AW-1:0] addr;
  logic          gwe_n, bwe_n, oe_n, sleep;
  logic [1:0]    lane_we_n;
  logic [DW-1:0] wdata, q;
  logic          q_drv;

  int nvec = 0;
  int nbad = 0;
  bit done = 0;
  logic [DW-1:0] shadow [64];

  always #2 clk = ~clk;

  fsram_burst_core #(.ADDR_W(AW), .LANE_W(8), .LANES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .burst_start(burst_start), .burst_adv(burst_adv),
    .addr(addr), .order_sel(order_sel), .gwe_n(gwe_n), .bwe_n(bwe_n),
    .lane_we_n(lane_we_n), .oe_n(oe_n), .sleep(sleep), .wdata(wdata),
    .q(q), .q_drv(q_drv)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    burst_start = 0; burst_adv = 0; gwe_n = 1; bwe_n = 1;
    lane_we_n = 2'b11; oe_n = 0; sleep = 0;
  endtask

  task automatic load_addr(input int a, input logic ord);
    idle();
    burst_start = 1; addr = AW'(a); order_sel = ord;
    @(negedge clk);
    idle();
  endtask

  function automatic int pat(input int a);
    return ((a * 16'h0351) ^ 16'hA5C3) & 16'hFFFF;
  endfunction

  function automatic int exp_addr(input int base, input int ord, input int b);
    int lo;
    lo = ord ? ((base & 3) ^ (b & 3)) : (((base & 3) + b) & 3);
    return (base & ~3) | lo;
  endfunction

  initial begin
    rst_n = 0; idle(); addr = '0; order_sel = 0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: write with no burst start goes to word 0
    gwe_n = 0; wdata = 16'h1234;
    #1 chk("R10 no drive during write", q_drv, 0);
    @(negedge clk); idle();
    load_addr(0, 0);
    #1 chk("R1 reset address is 0", q, 16'h1234);
    chk("R10 drive on read", q_drv, 1);
    @(negedge clk);

    // fill every word with gwe_n
    for (int a = 0; a < 64; a++) begin
      load_addr(a, 0);
      gwe_n = 0; bwe_n = 1; lane_we_n = 2'b11; wdata = DW'(pat(a));
      shadow[a] = DW'(pat(a));
      @(negedge clk); idle();
    end
    load_addr(63, 0);
    #1 chk("R2 full write", q, pat(63));
    @(negedge clk);

    // R5 R6 R7 R9 R12: burst order sweeps
    for (int ord = 0; ord < 2; ord++) begin
      for (int s = 0; s < 4; s++) begin
        int base;
        base = (((s + ord * 5 + 1) & 15) << 2) | s;
        load_addr(base, ord[0]);
        for (int b = 0; b < 6; b++) begin
          burst_adv = 1;
          order_sel = ~ord[0];
          #1;
          if (ord == 1) chk("R5 R12 interleaved beat", q, shadow[exp_addr(base, 1, b)]);
          else          chk("R6 R12 linear beat", q, shadow[exp_addr(base, 0, b)]);
          if (b >= 4) chk("R7 wrap", q, shadow[exp_addr(base, ord, b - 4)]);
          @(negedge clk);
        end
        idle();
      end
    end

    // R8: start beats a simultaneous advance
    load_addr(45, 1);
    burst_adv = 1; @(negedge clk); @(negedge clk);
    burst_start = 1; burst_adv = 1; addr = 6'd18; order_sel = 1;
    @(negedge clk); idle();
    #1 chk("R8 restart at beat 0", q, shadow[18]);
    burst_adv = 1; @(negedge clk); idle();
    #1 chk("R8 next beat after restart", q, shadow[19]);
    @(negedge clk);

    // R2 R3 R4 R10: every write-control combination
    load_addr(40, 0);
    for (int c = 0; c < 16; c++) begin
      logic [1:0] en;
      logic [15:0] d;
      gwe_n = c[3]; bwe_n = c[2]; lane_we_n = c[1:0];
      d = 16'h1111 * (c + 1) ^ 16'h0F0F;
      wdata = d;
      if (!c[3])      en = 2'b11;
      else if (!c[2]) en = ~c[1:0];
      else            en = 2'b00;
      #1 chk("R10 drive only on read", q_drv, (en == 0));
      @(negedge clk);
      if (en[0]) shadow[40][7:0]  = d[7:0];
      if (en[1]) shadow[40][15:8] = d[15:8];
      idle();
      #1;
      if (!c[3])      chk("R2 global write", q, shadow[40]);
      else if (en != 0) chk("R3 lane write", q, shadow[40]);
      else            chk("R4 read leaves data", q, shadow[40]);
      @(negedge clk);
    end

    // R10: oe_n high
    oe_n = 1;
    #1 chk("R10 oe_n high no drive", q_drv, 0);
    chk("R10 q zero when undriven", q, 0);
    @(negedge clk); idle();

    // R11: sleep blocks write, drive, start and advance
    load_addr(41, 1);
    sleep = 1; gwe_n = 0; wdata = 16'hDEAD; burst_adv = 1;
    #1 chk("R11 no drive in sleep", q_drv, 0);
    @(negedge clk);
    burst_start = 1; addr = 6'd7;
    @(negedge clk); idle();
    #1 chk("R11 address and data kept", q, shadow[41]);
    chk("R11 drive after wake", q_drv, 1);
    burst_adv = 1; @(negedge clk); idle();
    #1 chk("R11 burst resumes at beat 1", q, shadow[40]);
    @(negedge clk);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      nvec++; nbad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

endmodule